// File: doc/BRIEF.md
# Run-Length Pixel Stream Expander

The block reads 16-bit words from the read side of a show-ahead FIFO and turns them into a stream of 4-bit pixel codes on a valid/ready output. Each word carries four nibbles. They are used starting with the lowest nibble. Most nibbles are pixel codes, and each one is passed straight to the output. When a pixel code equals the code read just before it, the next nibble is not a pixel. It is a length field that asks for extra copies of that pixel.

A length field with its top bit clear holds the copy count in its low three bits. A length field with its top bit set gives, in its low three bits, how many count nibbles follow. Those nibbles build a wider count, lowest nibble first. The block stops whenever the FIFO runs dry or the consumer applies backpressure, and carries on from where it stopped. A start pulse begins a new transfer. An enable input pauses all decoding, and an idle output shows that nothing is in progress.

Top module: `rle_pix_expander`

## Requirements
- R1: After reset, `idle` is 1, `pix_valid` is 0 and `in_rd` is 0.
- R2: Nibbles are used in the order bits [3:0], [7:4], [11:8], [15:12] of each word. `in_rd` pops a word only when the next nibble to use is bits [3:0] and `in_empty` is 0. The popped word is the word shown on `in_data` in that same cycle.
- R3: Each pixel nibble produces exactly one output pixel with that code, in stream order. A stream with no code equal to the code before it passes through unchanged.
- R4: A pixel that equals the previous pixel code makes the next nibble a length field. If bit 3 of that field is 0, bits [2:0] give the number of extra copies of the pixel (0 to 7, and 0 adds none). No FIFO word is popped while copies are being emitted.
- R5: If bit 3 of the length field is 1, bits [2:0] give N, the number of count nibbles that follow (0 to 7). The count is the sum of count nibble k shifted left by 4*k, for k from 0. When N is 0 the count is 0.
- R6: The copy count is CNT_W bits wide (16 by default). A count nibble that would land at or above bit CNT_W is still consumed, but its value is dropped.
- R7: After a run, the repeated pixel stays the previous pixel. If the same code comes again, it is emitted and is followed by another length field.
- R8: At reset and on `start`, the previous pixel is set to a value that matches no 4-bit code. `start` also moves back to nibble position 0, drops any field in progress and any pending output, and `idle` is 1 in the following cycle.
- R9: When the FIFO is empty in the middle of a word or a field, the block holds its state and resumes that field once data arrives. While `pix_valid` is 1 and `pix_ready` is 0, `pix_data` stays stable.
- R10: While `en` is 0, no word is popped and no new pixel is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Decoding enable; 0 pauses all progress |
| start | input | 1 | One-cycle pulse that begins a new transfer |
| in_data | input | 16 | FIFO head word (show-ahead) |
| in_empty | input | 1 | FIFO has no word |
| in_rd | output | 1 | Pop the FIFO head word this cycle |
| pix_valid | output | 1 | Output pixel is valid |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_data | output | 4 | Output pixel code |
| idle | output | 1 | No field, partial word or pending pixel |

## Verification
Several corner cases get targeted tests. The first pixel after reset or `start` is chosen so that it would equal a wrongly zeroed previous pixel. A decoder that failed to clear that register would then read the following pixel as a length field and drop it. Runs cover a zero immediate count, an extended count with no count nibbles, a 256-copy count, and a count whose fifth nibble must be dropped by the 16-bit counter. A decoder that mishandled these would emit the wrong number of copies, or would fall out of step and read count nibbles as pixels. Random FIFO gaps and random `pix_ready` backpressure stop the block in the middle of words and fields. A decoder that lost its position would emit a shifted or corrupted stream, and the scoreboard would show a mismatch at the first wrong pixel.

// File: rtl/rle_pix_expander.sv
module rle_pix_expander #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        start,
  input  logic [15:0] in_data,
  input  logic        in_empty,
  output logic        in_rd,
  output logic        pix_valid,
  input  logic        pix_ready,
  output logic [3:0]  pix_data,
  output logic        idle
);
  localparam logic [4:0] NO_MATCH = 5'h10;

  typedef enum logic [1:0] {PH_PIX, PH_LEN, PH_EXT, PH_RUN} phase_t;

  phase_t           ph;
  logic [1:0]       slot;
  logic [15:0]      word;
  logic [4:0]       prev;
  logic [2:0]       xleft, xidx;
  logic [CNT_W-1:0] cnt;

  logic [3:0]       nib;
  logic             nib_ok, slot_free, take, emit;
  logic [CNT_W-1:0] ext_val;

  assign nib       = (slot == 2'd0) ? in_data[3:0] : word[{slot, 2'b00} +: 4];
  assign nib_ok    = (slot != 2'd0) || !in_empty;
  assign slot_free = !pix_valid || pix_ready;
  assign take      = en && !start && nib_ok && (ph != PH_RUN) && (ph != PH_PIX || slot_free);
  assign emit      = en && !start && slot_free && ((ph == PH_PIX && nib_ok) || ph == PH_RUN);
  assign in_rd     = take && (slot == 2'd0);
  assign ext_val   = cnt | (CNT_W'(nib) << {xidx, 2'b00});
  assign idle      = (ph == PH_PIX) && (slot == 2'd0) && !pix_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      ph        <= PH_PIX;
      slot      <= 2'd0;
      word      <= '0;
      prev      <= NO_MATCH;
      xleft     <= '0;
      xidx      <= '0;
      cnt       <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      if (pix_valid && pix_ready) pix_valid <= 1'b0;
      if (emit) begin
        pix_valid <= 1'b1;
        pix_data  <= (ph == PH_PIX) ? nib : prev[3:0];
      end
      if (take) begin
        slot <= slot + 2'd1;
        if (slot == 2'd0) word <= in_data;
      end
      unique case (ph)
        PH_PIX: if (take) begin
          prev <= {1'b0, nib};
          if ({1'b0, nib} == prev) ph <= PH_LEN;
        end
        PH_LEN: if (take) begin
          if (nib[3]) begin
            xleft <= nib[2:0];
            xidx  <= '0;
            cnt   <= '0;
            ph    <= (nib[2:0] == 3'd0) ? PH_PIX : PH_EXT;
          end else begin
            cnt <= CNT_W'(nib[2:0]);
            ph  <= (nib[2:0] == 3'd0) ? PH_PIX : PH_RUN;
          end
        end
        PH_EXT: if (take) begin
          cnt   <= ext_val;
          xidx  <= xidx + 3'd1;
          xleft <= xleft - 3'd1;
          if (xleft == 3'd1) ph <= (ext_val == '0) ? PH_PIX : PH_RUN;
        end
        PH_RUN: if (emit) begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) ph <= PH_PIX;
        end
        default: ph <= PH_PIX;
      endcase
    end
  end

  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> !in_empty);

  // R4
  run_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RUN) |-> !in_rd);

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> idle);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready && !start) |=> (pix_valid && $stable(pix_data)));

  // R10
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !in_rd);
endmodule

// File: tb/rle_pix_expander_tb.sv
module rle_pix_expander_tb;
  localparam int CLK_PERIOD = 10;

  typedef logic [3:0] nib_arr_t[];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        start = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_empty = 1'b1;
  logic        in_rd;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [3:0]  pix_data;
  logic        idle;

  logic [15:0] feed_q[$];
  logic [15:0] fq[$];
  logic [3:0]  exp_q[$];
  string       cur_req = "R1";
  int          checks = 0;
  int          fails = 0;
  bit          stall_in = 0;
  bit          stall_out = 0;
  bit          finished = 0;
  bit          will_pop = 0;
  bit          seen = 0;
  logic [3:0]  seen_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  rle_pix_expander u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start),
    .in_data(in_data), .in_empty(in_empty), .in_rd(in_rd),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .idle(idle)
  );

  // FIFO model, backpressure and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (will_pop && fq.size() > 0) void'(fq.pop_front());
      if (seen) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected pixel actual=%h expected=none", cur_req, seen_pix);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          if (seen_pix !== e) begin
            fails++;
            $display("FAIL %s: pixel actual=%h expected=%h", cur_req, seen_pix, e);
          end
        end
      end
      while (feed_q.size() > 0) fq.push_back(feed_q.pop_front());
      in_empty  = (fq.size() == 0) || (stall_in && ($urandom % 3 == 0));
      in_data   = (fq.size() > 0) ? fq[0] : 16'h0;
      pix_ready = stall_out ? ($urandom % 2 == 0) : 1'b1;
      #1;
      will_pop = in_rd;
      seen     = pix_valid && pix_ready;
      seen_pix = pix_data;
    end
  end

  task automatic send(input nib_arr_t nb, input string req);
    int i;
    int n;
    logic [4:0] pv;
    cur_req = req;
    n = nb.size();
    i = 0;
    pv = 5'h10;
    while (i < n) begin
      logic [3:0] p;
      logic [15:0] c;
      p = nb[i];
      i++;
      exp_q.push_back(p);
      if ({1'b0, p} == pv && i < n) begin
        logic [3:0] l;
        l = nb[i];
        i++;
        c = 16'h0;
        if (l[3]) begin
          for (int j = 0; j < int'(l[2:0]); j++) begin
            if (j < 4 && i < n) c = c | (16'(nb[i]) << (4 * j));
            i++;
          end
        end else begin
          c = 16'(l[2:0]);
        end
        for (int k = 0; k < int'(c); k++) exp_q.push_back(p);
      end
      pv = {1'b0, p};
    end
    for (int w = 0; w < n; w += 4)
      feed_q.push_back({nb[w+3], nb[w+2], nb[w+1], nb[w]});
  endtask

  task automatic finish_test(input string req);
    int t;
    t = 0;
    while (t < 5000 && !(exp_q.size() == 0 && fq.size() == 0 && feed_q.size() == 0 && idle)) begin
      @(negedge clk);
      #2;
      t++;
    end
    checks++;
    if (t >= 5000) begin
      fails++;
      $display("FAIL %s: drain timeout actual=%0d left expected=0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2;
    checks++;
    if (idle !== 1'b1) begin
      fails++;
      $display("FAIL R8: idle after start actual=%b expected=1", idle);
    end
  endtask

  initial begin
    nib_arr_t nl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    checks++;
    if (idle !== 1'b1 || pix_valid !== 1'b0 || in_rd !== 1'b0) begin
      fails++;
      $display("FAIL R1: idle/valid/rd actual=%b%b%b expected=100", idle, pix_valid, in_rd);
    end

    // R8: first pixel 0 must not match the reset value of the previous pixel
    nl = '{4'h0, 4'h1, 4'h2, 4'h3};
    send(nl, "R8");
    finish_test("R8");

    // R3, R2: no repeats, nibble order across words
    nl = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8,
           4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF, 4'h0};
    send(nl, "R3");
    finish_test("R2");

    // R4: immediate counts, including zero
    nl = '{4'h5, 4'h5, 4'h3, 4'h7, 4'h7, 4'h0, 4'h2, 4'h1};
    send(nl, "R4");
    finish_test("R4");

    // R5: extended count 0x14 and extended with no count nibbles
    nl = '{4'h2, 4'h2, 4'hA, 4'h4, 4'h1, 4'h9, 4'h9, 4'h8};
    send(nl, "R5");
    finish_test("R5");

    // R5: count 0x0100
    nl = '{4'hA, 4'hA, 4'hC, 4'h0, 4'h0, 4'h1, 4'h0, 4'h5};
    send(nl, "R5");
    finish_test("R5");

    // R6: fifth count nibble dropped by the 16-bit counter
    nl = '{4'hC, 4'hC, 4'hD, 4'h1, 4'h0, 4'h0, 4'h0, 4'hF};
    send(nl, "R6");
    finish_test("R6");

    // R7: same pixel after a run starts another length field
    nl = '{4'h6, 4'h6, 4'h1, 4'h6, 4'h2, 4'h3, 4'h4, 4'h5};
    send(nl, "R7");
    finish_test("R7");

    // R9: random FIFO gaps and output backpressure across mixed fields
    stall_in = 1;
    stall_out = 1;
    nl = '{4'h3, 4'h3, 4'h2, 4'h4, 4'h4, 4'h9, 4'h2, 4'h0,
           4'h1, 4'h1, 4'h1, 4'h5, 4'h6, 4'h6, 4'h0, 4'h7,
           4'h7, 4'h4, 4'hB, 4'hB, 4'hA, 4'h3, 4'h1, 4'h8};
    send(nl, "R9");
    finish_test("R9");
    stall_in = 0;
    stall_out = 0;

    // R8: start clears the previous pixel between transfers
    nl = '{4'h1, 4'h2, 4'h3, 4'h4};
    send(nl, "R8");
    finish_test("R8");
    pulse_start();
    nl = '{4'h4, 4'h5, 4'h6, 4'h7};
    send(nl, "R8");
    finish_test("R8");

    // R10: enable low blocks pops and output
    @(negedge clk);
    en = 1'b0;
    nl = '{4'hE, 4'hD, 4'hC, 4'hB};
    send(nl, "R10");
    begin
      bit bad;
      bad = 0;
      repeat (12) begin
        @(negedge clk);
        #2;
        if (in_rd !== 1'b0 || pix_valid !== 1'b0) bad = 1;
      end
      checks++;
      if (bad) begin
        fails++;
        $display("FAIL R10: activity while disabled actual=1 expected=0");
      end
    end
    @(negedge clk);
    en = 1'b1;
    finish_test("R10");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule